// File: doc/BRIEF.md
# Reversible Binary Counter with Ripple-Clock Output

This block is a small binary counter that counts up or down by one on each rising clock edge while its active-low enable is asserted. It also has an active-low load strobe. When the strobe is low, the count takes the value on the load data bus at once, with no clock edge needed. The load has priority over counting and over the synchronous reset.

Two outputs support cascading. The terminal-count flag is high when the count sits at the last value for the current direction: all ones when counting up, all zeros when counting down. The active-low ripple output passes the low phase of the clock, but only while the terminal-count flag is high and counting is enabled. Wider counters are built by feeding that output to the clock of the next stage. Another option is to combine terminal-count flags into the enable of later stages.

Top module: `updn_ripple_counter`

## Requirements
- R1: While `load_n` is low, `count` equals `load_val` immediately, with no clock edge needed, and this overrides counting. After `load_n` rises, the count keeps the loaded value, provided `load_val` stayed stable while `load_n` was low.
- R2: With `load_n` high and `cnt_en_n` high at a rising edge, `count` keeps its value.
- R3: With `load_n` high and `cnt_en_n` low at a rising edge, `count` goes up by one when `dir_down` is 0 and down by one when `dir_down` is 1.
- R4: When counting up, the count wraps from all ones (15 at the default width) to 0. When counting down, it wraps from 0 to all ones.
- R5: `term_cnt` is 1 exactly when (`dir_down`=0 and `count` is all ones) or (`dir_down`=1 and `count` is 0). The enable has no effect on it, and it follows a change of `dir_down` without waiting for a clock edge.
- R6: `ripple_n` is 0 only while `clk` is low, `term_cnt` is 1 and `cnt_en_n` is 0. Otherwise it is 1.
- R7: `ripple_n` is 1 throughout every high phase of `clk`.
- R8: A high `rst` at a rising edge, with `load_n` high, clears the count to 0. A low `load_n` takes priority over `rst`.
- R9: `dir_down` and `cnt_en_n` act only through their values at the rising edge. Changing them between edges and restoring them before the edge leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count changes on its rising edge |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low asynchronous load strobe |
| load_val | input | W | Value forced onto the count during load |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | Direction: 0 counts up, 1 counts down |
| count | output | W | Current count |
| term_cnt | output | 1 | High at the last value for the current direction |
| ripple_n | output | 1 | Active-low gated copy of the clock low phase |

## Verification
The counter is driven through long runs in each direction that cross the wrap point. These show whether the step sign and the modular wrap are right. Hold periods and inputs that are toggled between edges and then restored separate edge-sampled behaviour from level-sensitive leakage. Loads are applied in the middle of the low phase, held across edges while counting is enabled, and combined with reset. These cases show whether the load acts at once, whether it takes priority, and whether the value is retained. The direction is flipped at terminal values with the enable both on and off. This shows that the flag ignores the enable while the ripple output obeys it in both clock phases.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
package updn_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/updn_step.sv
`timescale 1ns/1ps
// Next-state arithmetic: +1, -1 or hold, modular in W bits.
module updn_step #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         dir_down,
  input  logic         cnt_en_n,
  output logic [W-1:0] nxt
);
  import updn_pkg::*;
  localparam logic [W-1:0] ONE = W'(1);

  dir_e dir;
  assign dir = dir_e'(dir_down);

  always_comb begin
    nxt = cur;
    if (!cnt_en_n) begin
      if (dir == DIR_DOWN) nxt = cur - ONE;
      else                 nxt = cur + ONE;
    end
  end
endmodule

// File: rtl/updn_term_decode.sv
`timescale 1ns/1ps
// Terminal value decode: all ones going up, all zeros going down.
module updn_term_decode #(
  parameter int W = 4
) (
  input  logic [W-1:0] val,
  input  logic         dir_down,
  output logic         term
);
  logic [W:0] ones_chain;
  logic [W:0] zero_chain;

  assign ones_chain[0] = 1'b1;
  assign zero_chain[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign ones_chain[i+1] = ones_chain[i] &  val[i];
    assign zero_chain[i+1] = zero_chain[i] & ~val[i];
  end

  assign term = dir_down ? zero_chain[W] : ones_chain[W];
endmodule

// File: rtl/updn_ripple_gate.sv
`timescale 1ns/1ps
// Active-low pulse during the clock low phase at the terminal value.
module updn_ripple_gate (
  input  logic clk,
  input  logic term,
  input  logic cnt_en_n,
  output logic ripple_n
);
  assign ripple_n = ~(term & ~cnt_en_n & ~clk);
endmodule

// File: rtl/updn_state_reg.sv
`timescale 1ns/1ps
// Count register with asynchronous load and a bypass so the load shows at once.
module updn_state_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q,
  output logic [W-1:0] shown
);
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)  q <= load_val;
    else if (rst) q <= '0;
    else          q <= nxt;
  end

  assign shown = load_n ? q : load_val;
endmodule

// File: rtl/updn_ripple_counter.sv
`timescale 1ns/1ps
module updn_ripple_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic [W-1:0] load_val,
  input  logic         cnt_en_n,
  input  logic         dir_down,
  output logic [W-1:0] count,
  output logic         term_cnt,
  output logic         ripple_n
);
  logic [W-1:0] q_reg;
  logic [W-1:0] q_nxt;

  updn_step #(.W(W)) u_step (
    .cur      (q_reg),
    .dir_down (dir_down),
    .cnt_en_n (cnt_en_n),
    .nxt      (q_nxt)
  );

  updn_state_reg #(.W(W)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .load_n   (load_n),
    .load_val (load_val),
    .nxt      (q_nxt),
    .q        (q_reg),
    .shown    (count)
  );

  updn_term_decode #(.W(W)) u_term (
    .val      (count),
    .dir_down (dir_down),
    .term     (term_cnt)
  );

  updn_ripple_gate u_gate (
    .clk      (clk),
    .term     (term_cnt),
    .cnt_en_n (cnt_en_n),
    .ripple_n (ripple_n)
  );
endmodule

// File: rtl/updn_ripple_counter_chk.sv
`timescale 1ns/1ps
module updn_ripple_counter_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         load_n,
  input logic [W-1:0] load_val,
  input logic         cnt_en_n,
  input logic         dir_down,
  input logic [W-1:0] count,
  input logic         term_cnt,
  input logic         ripple_n
);
  localparam logic [W-1:0] ONE = W'(1);

  // R1
  load_visible_chk: assert property (@(posedge clk)
    !load_n |-> count == load_val);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && cnt_en_n) ##1 load_n |-> $stable(count));

  // R3 R4
  step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && !cnt_en_n && !dir_down) ##1 load_n |-> count == $past(count) + ONE);

  // R3 R4
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (load_n && !cnt_en_n && dir_down) ##1 load_n |-> count == $past(count) - ONE);

  // R5
  term_decode_chk: assert property (@(negedge clk)
    term_cnt == (dir_down ? (count == '0) : (count == '1)));

  // R6
  ripple_low_chk: assert property (@(posedge clk) disable iff (rst)
    ripple_n == !(term_cnt && !cnt_en_n));

  // R7
  ripple_high_chk: assert property (@(negedge clk)
    ripple_n);

  // R8
  sync_clear_chk: assert property (@(posedge clk)
    (rst && load_n) ##1 load_n |-> count == '0);
endmodule

bind updn_ripple_counter updn_ripple_counter_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load_n   (load_n),
  .load_val (load_val),
  .cnt_en_n (cnt_en_n),
  .dir_down (dir_down),
  .count    (count),
  .term_cnt (term_cnt),
  .ripple_n (ripple_n)
);

// File: tb/updn_ripple_counter_tb.sv
`timescale 1ns/1ps
module updn_ripple_counter_tb;
  localparam int W    = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst      = 1'b1;
  logic         load_n   = 1'b1;
  logic [W-1:0] load_val = '0;
  logic         cnt_en_n = 1'b1;
  logic         dir_down = 1'b0;
  logic [W-1:0] count;
  logic         term_cnt;
  logic         ripple_n;

  int n_run  = 0;
  int n_fail = 0;
  int model_q = 0;
  bit done = 1'b0;

  updn_ripple_counter #(.W(W)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .load_n   (load_n),
    .load_val (load_val),
    .cnt_en_n (cnt_en_n),
    .dir_down (dir_down),
    .count    (count),
    .term_cnt (term_cnt),
    .ripple_n (ripple_n)
  );

  function automatic int exp_term();
    if (!load_n) return dir_down ? int'(load_val == 0) : int'(load_val == MAXV);
    return dir_down ? int'(model_q == 0) : int'(model_q == MAXV);
  endfunction

  task automatic chk(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // One clock: model update at the edge, checks in the high and low phases.
  task automatic cycle(string req);
    @(posedge clk);
    if (!load_n)        model_q = int'(load_val);
    else if (rst)       model_q = 0;
    else if (!cnt_en_n) model_q = dir_down ? (model_q + MAXV) % (MAXV + 1)
                                           : (model_q + 1) % (MAXV + 1);
    #1;
    chk(req, int'(count), load_n ? model_q : int'(load_val));
    chk("R5", int'(term_cnt), exp_term());
    chk("R7", int'(ripple_n), 1);
    @(negedge clk);
    #0.5;
    chk("R6", int'(ripple_n), (exp_term() == 1 && !cnt_en_n) ? 0 : 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL R3 watchdog: got hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    cycle("R8");
    cycle("R8");
    chk("R8", int'(count), 0);
    rst = 1'b0;

    // R3 R4 count up across the wrap
    cnt_en_n = 1'b0;
    dir_down = 1'b0;
    for (int i = 0; i < 20; i++) cycle("R4");

    // R2 hold
    cnt_en_n = 1'b1;
    for (int i = 0; i < 3; i++) cycle("R2");

    // R1 immediate load in the low phase, held over an edge
    load_val = 4'd15;
    load_n   = 1'b0;
    #0.5;
    chk("R1", int'(count), 15);
    cycle("R1");
    load_n = 1'b1;
    #0.2;
    chk("R1", int'(count), 15);

    // R5 flag follows direction at once, ignores enable
    chk("R5", int'(term_cnt), 1);
    dir_down = 1'b1;
    #0.2;
    chk("R5", int'(term_cnt), 0);
    dir_down = 1'b0;
    #0.2;
    chk("R5", int'(term_cnt), 1);
    chk("R6", int'(ripple_n), 1);
    cycle("R2");

    // R6 ripple goes low once enabled at the terminal value
    cnt_en_n = 1'b0;
    #0.2;
    chk("R6", int'(ripple_n), 0);
    cycle("R4");

    // R3 R4 count down across the wrap
    dir_down = 1'b1;
    for (int i = 0; i < 20; i++) cycle("R4");

    // R9 toggles between edges, restored before the edge
    dir_down = 1'b0;
    cnt_en_n = 1'b1;
    #0.5;
    dir_down = 1'b1;
    cnt_en_n = 1'b0;
    cycle("R9");
    cnt_en_n = 1'b1;
    #0.5;
    cnt_en_n = 1'b0;
    dir_down = 1'b0;
    #0.3;
    dir_down = 1'b1;
    cycle("R9");

    // R1 load overrides enabled counting
    load_val = 4'd6;
    load_n   = 1'b0;
    cycle("R1");
    cycle("R1");
    load_n = 1'b1;
    cycle("R3");
    chk("R3", int'(count), 5);

    // R8 load wins over reset, then reset clears
    rst      = 1'b1;
    load_val = 4'd10;
    load_n   = 1'b0;
    cycle("R8");
    chk("R8", int'(count), 10);
    load_n = 1'b1;
    cycle("R8");
    chk("R8", int'(count), 0);
    rst = 1'b0;
    cycle("R3");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule